// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a cycle-level model of a synchronous, pipelined burst static RAM with byte-lane write control. It holds a parameterised array of words. Each word is made of nine-bit lanes: eight data bits and one parity bit. An access starts when one of two address strobes loads an external address. The first strobe serves a processor and reads. The second serves a cache controller, and it reads or writes. Further words of a four-word burst follow under an advance input, in either linear or interleaved order.

Read data passes through two registers before it reaches the bus. The bus is modelled as separate data-in, data-out and drive-enable ports. Three chip selects qualify each address strobe. An asynchronous output enable and a sleep input can force the bus to high impedance at any time. After sleep ends, the block ignores the inputs for a fixed number of clock edges.

Top module: `pbsram_model`

## Requirements
- R1: After reset, dataOe is 0 and no burst is active.
- R2: When procStrobeN is sampled low with selPrimN low and the chip selected, the block loads addrIn and reads that word. On that edge globalWrN, byteWrN, laneWrN and advanceN have no effect.
- R3: A controller start (ctrlStrobeN low) needs procStrobeN high on the same edge, and the write controls are sampled on that same edge. When both strobes are low, the edge is a processor start and does not write.
- R4: A word read on one rising edge is driven on dataOut, with dataOe 1, after the following rising edge.
- R5: Lane k occupies bits [9k+8:9k], with bit 9k+8 as its parity. globalWrN low writes every lane. Otherwise lane k is written only when byteWrN and laneWrN[k] are both low.
- R6: After any edge that writes, dataOe is 0 for the next cycle, whatever the value of outEnN.
- R7: In linear order (burstInterleave 0), the burst offset after n advances is (start + n) mod 4. An edge with advanceN high keeps the current address. After four advances the burst is back at its start word.
- R8: In interleaved order (burstInterleave 1), the burst offset after n advances is start XOR n.
- R9: The chip is selected when selPrimN is 0, selHighAct is 1 and selLowN is 0. If an address strobe is sampled while the chip is deselected, any burst ends and dataOe is 0 after that edge. After a selected start, data is driven two edges later.
- R10: When selPrimN is high, procStrobeN has no effect: an active burst continues at its own address.
- R11: outEnN high forces dataOe to 0 at once, with no clock edge needed.
- R12: While sleepIn is high, dataOe is 0 and the memory contents are kept. The first WAKE_CYCLES edges after sleepIn falls are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rstN | input | 1 | Active-low asynchronous reset of control state |
| addrIn | input | AW | External word address |
| procStrobeN | input | 1 | Processor address strobe, active low |
| ctrlStrobeN | input | 1 | Cache-controller address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| selPrimN | input | 1 | Primary chip select, active low; also gates procStrobeN |
| selHighAct | input | 1 | Chip select, active high |
| selLowN | input | 1 | Chip select, active low |
| globalWrN | input | 1 | Write of all lanes, active low |
| byteWrN | input | 1 | Enables per-lane writes, active low |
| laneWrN | input | LANES | Per-lane write enables, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| burstInterleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleepIn | input | 1 | Sleep request, active high |
| dataIn | input | LANES*9 | Write data |
| dataOut | output | LANES*9 | Read data |
| dataOe | output | 1 | Bus drive enable |

## Verification
The bench builds the block with its default parameters: DEPTH 64, LANES 4 and WAKE_CYCLES 2. Four lanes allow a lane mask that mixes written and skipped lanes in a single word, so the gating of each lane is checked. A 64-word array holds two separate four-word groups, so a wrapped linear burst and an interleaved burst can be read back without disturbing each other. Two wake cycles give a short window in which the bench checks that a start issued at once after sleep is lost.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic loadAddr;  // capture external address, restart burst
    logic step;      // advance burst counter before access
    logic rdEn;      // read addressed word into pipeline
    logic wrEn;      // write masked lanes
    logic kill;      // flush read pipeline
  } sramStrobe_t;

  localparam int LANE_BITS = 9;
endpackage

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl
  import pbsram_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int WAKE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              selPrimN,
  input  logic              selHighAct,
  input  logic              selLowN,
  input  logic              globalWrN,
  input  logic              byteWrN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              sleepIn,
  output sramStrobe_t       strb,
  output logic [LANES-1:0]  laneMask
);
  localparam int WCW = $clog2(WAKE_CYCLES + 1);

  logic [WCW-1:0] wakeCnt;
  logic           burstActive;
  logic           chipSel, awake, procStart, ctrlStart, anyWr;

  always_comb begin
    chipSel   = !selPrimN && selHighAct && !selLowN;
    awake     = !sleepIn && (wakeCnt == '0);
    procStart = !procStrobeN && !selPrimN;
    ctrlStart = !ctrlStrobeN && procStrobeN;
    if (!globalWrN)    laneMask = '1;
    else if (!byteWrN) laneMask = ~laneWrN;
    else               laneMask = '0;
    anyWr = |laneMask;

    strb = '0;
    if (!awake) begin
      strb.kill = 1'b1;
    end else if (procStart) begin
      if (chipSel) begin
        strb.loadAddr = 1'b1;
        strb.rdEn     = 1'b1;
      end else begin
        strb.kill = 1'b1;
      end
    end else if (ctrlStart) begin
      if (chipSel) begin
        strb.loadAddr = 1'b1;
        strb.wrEn     = anyWr;
        strb.rdEn     = !anyWr;
      end else begin
        strb.kill = 1'b1;
      end
    end else if (burstActive) begin
      strb.step = !advanceN;
      strb.wrEn = anyWr;
      strb.rdEn = !anyWr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      wakeCnt     <= '0;
    end else begin
      if (strb.kill)          burstActive <= 1'b0;
      else if (strb.loadAddr) burstActive <= 1'b1;
      if (sleepIn)             wakeCnt <= WCW'(WAKE_CYCLES);
      else if (wakeCnt != '0)  wakeCnt <= wakeCnt - 1'b1;
    end
  end

  // R2
  proc_start_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (awake && procStart && chipSel) |-> (!strb.wrEn && !strb.step));

  // R12
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepIn) |-> !(strb.rdEn || strb.wrEn));

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !burstActive);
endmodule

// File: rtl/pbsram_datapath.sv
module pbsram_datapath
  import pbsram_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LANES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  sramStrobe_t                 strb,
  input  logic [LANES-1:0]            laneMask,
  input  logic [$clog2(DEPTH)-1:0]    addrIn,
  input  logic                        burstInterleave,
  input  logic [LANES*LANE_BITS-1:0]  dataIn,
  input  logic                        outEnN,
  input  logic                        sleepIn,
  output logic [LANES*LANE_BITS-1:0]  dataOut,
  output logic                        dataOe
);
  localparam int AW    = $clog2(DEPTH);
  localparam int WIDTH = LANES * LANE_BITS;

  logic [AW-3:0]    baseAddr;
  logic [1:0]       startOff, burstCnt, nextCnt, accCnt, accOff;
  logic [AW-1:0]    accAddr;
  logic [WIDTH-1:0] memArr [DEPTH];
  logic [WIDTH-1:0] rdData, outData;
  logic             rdValid, outValid, wrBlank;

  always_comb begin
    nextCnt = burstCnt + 2'd1;
    accCnt  = strb.step ? nextCnt : burstCnt;
    accOff  = burstInterleave ? (startOff ^ accCnt) : (startOff + accCnt);
    accAddr = strb.loadAddr ? addrIn : {baseAddr, accOff};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      startOff <= '0;
      burstCnt <= '0;
    end else if (strb.loadAddr) begin
      baseAddr <= addrIn[AW-1:2];
      startOff <= addrIn[1:0];
      burstCnt <= '0;
    end else if (strb.step) begin
      burstCnt <= nextCnt;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (strb.wrEn && laneMask[k])
        memArr[accAddr][k*LANE_BITS +: LANE_BITS] <= dataIn[k*LANE_BITS +: LANE_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.rdEn) rdData <= memArr[accAddr];
    outData <= rdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      outValid <= 1'b0;
      wrBlank  <= 1'b0;
    end else begin
      if (strb.kill) begin
        rdValid  <= 1'b0;
        outValid <= 1'b0;
      end else begin
        rdValid  <= strb.rdEn;
        outValid <= rdValid;
      end
      wrBlank <= strb.wrEn;
    end
  end

  assign dataOut = outData;
  assign dataOe  = outValid && !wrBlank && !outEnN && !sleepIn;

  // R6
  write_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> !dataOe);

  // R12
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepIn |-> !dataOe);

  // R7
  burst_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.loadAddr) |=> (burstCnt == $past(burstCnt) + 2'd1));

  // R9
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.kill |=> !dataOe);
endmodule

// File: rtl/pbsram_model.sv
module pbsram_model
  import pbsram_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int LANES       = 4,
  parameter int WAKE_CYCLES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [$clog2(DEPTH)-1:0]    addrIn,
  input  logic                        procStrobeN,
  input  logic                        ctrlStrobeN,
  input  logic                        advanceN,
  input  logic                        selPrimN,
  input  logic                        selHighAct,
  input  logic                        selLowN,
  input  logic                        globalWrN,
  input  logic                        byteWrN,
  input  logic [LANES-1:0]            laneWrN,
  input  logic                        outEnN,
  input  logic                        burstInterleave,
  input  logic                        sleepIn,
  input  logic [LANES*LANE_BITS-1:0]  dataIn,
  output logic [LANES*LANE_BITS-1:0]  dataOut,
  output logic                        dataOe
);
  sramStrobe_t      strb;
  logic [LANES-1:0] laneMask;

  pbsram_ctrl #(.LANES(LANES), .WAKE_CYCLES(WAKE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .selPrimN(selPrimN), .selHighAct(selHighAct), .selLowN(selLowN),
    .globalWrN(globalWrN), .byteWrN(byteWrN), .laneWrN(laneWrN),
    .sleepIn(sleepIn), .strb(strb), .laneMask(laneMask)
  );

  pbsram_datapath #(.DEPTH(DEPTH), .LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .laneMask(laneMask),
    .addrIn(addrIn), .burstInterleave(burstInterleave), .dataIn(dataIn),
    .outEnN(outEnN), .sleepIn(sleepIn), .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: tb/pbsram_model_tb.sv
`timescale 1ns/1ps
module pbsram_model_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  addrIn;
  logic        procStrobeN, ctrlStrobeN, advanceN;
  logic        selPrimN, selHighAct, selLowN;
  logic        globalWrN, byteWrN;
  logic [3:0]  laneWrN;
  logic        outEnN, burstInterleave, sleepIn;
  logic [35:0] dataIn, dataOut;
  logic        dataOe;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pbsram_model u_dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .selPrimN(selPrimN),
    .selHighAct(selHighAct), .selLowN(selLowN), .globalWrN(globalWrN),
    .byteWrN(byteWrN), .laneWrN(laneWrN), .outEnN(outEnN),
    .burstInterleave(burstInterleave), .sleepIn(sleepIn), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  typedef struct packed {
    logic        pN, cN, aN, gN, bN;
    logic [3:0]  lN;
    logic [5:0]  addr;
    logic [35:0] din;
    logic        expOe;
    logic [35:0] expD;
    logic [3:0]  req;
  } vec_t;

  localparam logic [35:0] F36 = 36'hFFFFFFFFF;
  localparam logic [35:0] D4 = 36'h144444444, D5 = 36'h255555555,
                          D6 = 36'h366666666, D7 = 36'h477777777,
                          D8 = 36'h588888888, MIX = 36'h007FC01FF;

  localparam vec_t VECS [17] = '{
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,6'd4,D4, 1'b0,36'h0,4'd3},  // R3 controller-start write at 4
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,6'd0,D5, 1'b0,36'h0,4'd7},  // R7 advance -> 5
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,6'd0,D6, 1'b0,36'h0,4'd7},  // R7 -> 6
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,6'd0,D7, 1'b0,36'h0,4'd7},  // R7 -> 7
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,6'd0,D8, 1'b0,36'h0,4'd7},  // R7 wrap -> 4
    '{1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,6'd5,36'h0,1'b0,36'h0,4'd4}, // R4 read start 5
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,6'd0,36'h0,1'b1,D5, 4'd4},  // R4 two-edge latency
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,6'd0,36'h0,1'b1,D6, 4'd7},  // R7
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,6'd0,36'h0,1'b1,D7, 4'd7},  // R7
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,6'd0,36'h0,1'b1,D8, 4'd7},  // R7 wrapped word
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,6'd0,36'h0,1'b1,D8, 4'd7},  // R7 hold address
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,6'd8,36'h0,1'b0,36'h0,4'd6}, // R6 write blanks pending read
    '{1'b1,1'b1,1'b1,1'b1,1'b0,4'hA,6'd0,F36, 1'b0,36'h0,4'd5},  // R5 lanes 0,2 written
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'h0,6'd0,F36, 1'b0,36'h0,4'd5},  // R5 byteWrN high: no write
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,6'd0,36'h0,1'b1,MIX, 4'd5},  // R5 readback
    '{1'b0,1'b1,1'b0,1'b0,1'b1,4'hF,6'd8,F36, 1'b1,MIX, 4'd2},  // R2 write ignored on start
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,6'd0,36'h0,1'b1,MIX, 4'd2}   // R2 word unchanged
  };

  task automatic drive(input logic pN, cN, aN, gN, bN, input logic [3:0] lN,
                       input logic [5:0] a, input logic [35:0] d);
    procStrobeN = pN; ctrlStrobeN = cN; advanceN = aN; globalWrN = gN;
    byteWrN = bN; laneWrN = lN; addrIn = a; dataIn = d;
  endtask

  task automatic idle(input logic aN);
    drive(1'b1, 1'b1, aN, 1'b1, 1'b1, 4'hF, 6'd0, 36'h0);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic expOe, input logic [35:0] expD);
    checks++;
    if (dataOe !== expOe || (expOe && dataOut !== expD)) begin
      errors++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
               req, dataOe, dataOut, expOe, expD);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1: run hung, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    selPrimN = 1'b0; selHighAct = 1'b1; selLowN = 1'b0;
    outEnN = 1'b0; burstInterleave = 1'b0; sleepIn = 1'b0;
    idle(1'b1);
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 1'b0, 36'h0);
    rstN = 1'b1;
    tick();
    expect_out("R1 idle after reset", 1'b0, 36'h0);

    for (int i = 0; i < 17; i++) begin
      drive(VECS[i].pN, VECS[i].cN, VECS[i].aN, VECS[i].gN, VECS[i].bN,
            VECS[i].lN, VECS[i].addr, VECS[i].din);
      tick();
      expect_out($sformatf("R%0d table row %0d", VECS[i].req, i), VECS[i].expOe, VECS[i].expD);
    end

    // R8 interleaved write burst from offset 1: words 9, 8, 11, 10
    burstInterleave = 1'b1;
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd9, 36'hA11111111); tick();
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 36'hB22222222); tick();
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 36'hC33333333); tick();
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 36'hD44444444); tick();
    expect_out("R8 write burst blanked", 1'b0, 36'h0);
    burstInterleave = 1'b0;
    // R2 advance ignored on processor start: first read is word 8
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'd8, 36'h0); tick();
    expect_out("R4 first edge", 1'b0, 36'h0);
    idle(1'b0); tick(); expect_out("R8 word8 / R2", 1'b1, 36'hB22222222);
    idle(1'b0); tick(); expect_out("R8 word9", 1'b1, 36'hA11111111);
    idle(1'b0); tick(); expect_out("R8 word10", 1'b1, 36'hD44444444);
    idle(1'b1); tick(); expect_out("R8 word11", 1'b1, 36'hC33333333);

    // R9 deselect at strobe ends burst after one edge
    selHighAct = 1'b0;
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'd8, 36'h0); tick();
    expect_out("R9 disable one edge", 1'b0, 36'h0);
    selHighAct = 1'b1;
    idle(1'b0); tick(); expect_out("R9 burst ended", 1'b0, 36'h0);
    idle(1'b0); tick(); expect_out("R9 burst ended", 1'b0, 36'h0);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'd10, 36'h0); tick();
    expect_out("R9 enable first edge", 1'b0, 36'h0);
    idle(1'b1); tick(); expect_out("R9 enable two edges", 1'b1, 36'hD44444444);
    selLowN = 1'b1;
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd8, 36'h0); tick();
    expect_out("R9 controller deselect", 1'b0, 36'h0);
    selLowN = 1'b0;
    idle(1'b1); tick(); expect_out("R9 no burst", 1'b0, 36'h0);

    // R10 blocked processor strobe continues burst at word 8
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'd8, 36'h0); tick();
    idle(1'b1); tick();
    selPrimN = 1'b1;
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'd9, 36'h0); tick();
    selPrimN = 1'b0;
    idle(1'b1); tick();
    expect_out("R10 strobe blocked", 1'b1, 36'hB22222222);

    // R11 asynchronous output enable
    outEnN = 1'b1; #1;
    expect_out("R11 oe high", 1'b0, 36'h0);
    outEnN = 1'b0; #1;
    expect_out("R11 oe low", 1'b1, 36'hB22222222);

    // R3 both strobes low: processor start, no write
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd8, F36); tick();
    idle(1'b1); tick();
    expect_out("R3 controller strobe needs processor high", 1'b1, 36'hB22222222);

    // R12 sleep
    sleepIn = 1'b1; #1;
    expect_out("R12 sleep async", 1'b0, 36'h0);
    tick(); tick();
    expect_out("R12 sleeping", 1'b0, 36'h0);
    sleepIn = 1'b0;
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'd9, 36'h0); tick();
    expect_out("R12 wake edge 1", 1'b0, 36'h0);
    tick();
    expect_out("R12 wake edge 2", 1'b0, 36'h0);
    idle(1'b1); tick();
    expect_out("R12 starts ignored", 1'b0, 36'h0);
    tick();
    expect_out("R12 starts ignored", 1'b0, 36'h0);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'd9, 36'h0); tick();
    idle(1'b1); tick();
    expect_out("R12 contents kept", 1'b1, 36'hA11111111);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule